// File: doc/BRIEF.md
# Redirection Interrupt Dispatcher

This block turns rising edges on a bank of interrupt input pins into interrupt messages addressed to a set of processor-local interrupt controllers. Each pin has a redirection entry, supplied as a flat input vector. The entry holds the vector number, the delivery mode, the destination mode, the polarity, the trigger mode, a mask bit and an 8-bit destination. When a pin's remembered state goes from low to high, the block reads that pin's entry, builds the message and works out which controllers should receive it. It then emits the result as a one-cycle strobe with a target bitmask, one bit per local controller.

Targets are resolved in one of three ways. In physical mode, destination 0xFF reaches every controller and any other value reaches only the controller with that ID. In logical mode, each controller's logical destination byte is matched against the destination. Lowest-priority delivery in logical mode uses no processor priorities. It picks one of the matched controllers with a rotating offset that advances once per message sent. Edges that arrive together are queued and served lowest pin first, one per cycle. The message is registered, so it appears on the cycle after the clock edge that samples the pin edge or releases it from the queue. A configuration that cannot be served raises a one-cycle error strobe instead of a message.

Top module: `irq_dispatcher`

## Requirements
- R1: After reset, no message or error strobe is raised until a pin rises.
- R2: A message is produced only when a pin goes from low to high. A pin held high gives no further message until it has been seen low again, and then a new rise gives a new message.
- R3: An entry whose mask bit (entry bit 14) is 1 sends nothing when its pin rises.
- R4: With delivery mode 7 (external controller), the message vector is taken from `ext_vector`. In every other mode it is taken from entry bits 7:0.
- R5: The message copies the entry's delivery mode (bits 10:8), destination mode (bit 11, 1 = logical), polarity (bit 12) as level, and trigger mode (bit 13).
- R6: In physical mode, destination (bits 22:15) 0xFF sets every bit of `msg_targets`. Any other value sets only bit d when d is below NUM_CPUS, and no bit otherwise.
- R7: Delivery mode 1 (lowest priority) with physical destination mode sends no message and pulses `cfg_error` for one cycle.
- R8: In logical mode, controller i is a target when byte i of `cpu_logical_ids` ANDed with the destination is nonzero.
- R9: In logical mode with no matching controller, no message and no error are produced, and the rotation offset is left unchanged.
- R10: Lowest-priority logical delivery with at least one match targets exactly one controller. That controller is the k-th matched one in ascending index order, where k = offset mod match count. The offset starts at 0 after reset and advances by one per such message.
- R11: Pins that rise in the same cycle are served in ascending pin order, one message per cycle on consecutive cycles.
- R12: `msg_valid` and `cfg_error` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Interrupt input pins |
| redir_table | input | NUM_PINS*23 | Redirection entries, 23 bits per pin, pin 0 in the low bits |
| ext_vector | input | 8 | Vector supplied by the external legacy controller |
| cpu_logical_ids | input | NUM_CPUS*8 | Logical destination byte of each local controller, controller 0 lowest |
| msg_valid | output | 1 | One-cycle message strobe |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode, 1 = logical |
| msg_level | output | 1 | Message level (entry polarity) |
| msg_trigger | output | 1 | Message trigger mode |
| msg_targets | output | NUM_CPUS | Bitmask of target controllers |
| cfg_error | output | 1 | One-cycle strobe for lowest priority with physical destination |

## Verification
Two things can fall in the same cycle. A fresh pin edge can arrive while queued edges are still being drained, and a lowest-priority rotation step can sit next to a delivery that finds no match and must leave the offset alone. The bench raises three pins at one clock edge with distinct vectors and checks that the vectors come out on three consecutive cycles in pin order with no gap. It also places a no-match lowest-priority request between rotating deliveries and checks that the next chosen controller is the one that follows the last one served, never one skipped over.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

    localparam int ENT_W  = 23;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_EXTINT = 3'd7
    } dmode_e;

    // Entry layout, most significant field first.
    typedef struct packed {
        logic [DEST_W-1:0] dest;      // 22:15
        logic              masked;    // 14
        logic              trig;      // 13
        logic              pol;       // 12
        logic              logical;   // 11
        dmode_e            dmode;     // 10:8
        logic [VEC_W-1:0]  vec;       // 7:0
    } route_ent_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SEND,
        ACT_ERROR
    } act_e;

    function automatic route_ent_t decode_entry(input logic [ENT_W-1:0] raw);
        return route_ent_t'(raw);
    endfunction

    function automatic logic [VEC_W-1:0] pick_vector(input route_ent_t e,
                                                     input logic [VEC_W-1:0] ext);
        return (e.dmode == DM_EXTINT) ? ext : e.vec;
    endfunction

endpackage

// File: rtl/irq_edge_arbiter.sv
module irq_edge_arbiter #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                grant_valid,
    output logic [NUM_PINS-1:0] grant
);
    logic [NUM_PINS-1:0] pin_seen;
    logic [NUM_PINS-1:0] pending;
    logic [NUM_PINS-1:0] cand;

    always_comb begin
        cand  = pending | (pin_in & ~pin_seen);
        grant = cand & (~cand + {{(NUM_PINS-1){1'b0}}, 1'b1});
        grant_valid = |cand;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_seen <= '0;
            pending  <= '0;
        end else begin
            pin_seen <= pin_in;
            pending  <= cand & ~grant;
        end
    end
endmodule

// File: rtl/irq_target_resolver.sv
module irq_target_resolver
    import irq_disp_pkg::*;
#(
    parameter int NUM_CPUS = 8
) (
    input  logic [DEST_W-1:0]          dest,
    input  logic                       logical,
    input  logic [NUM_CPUS*DEST_W-1:0] cpu_logical_ids,
    output logic [NUM_CPUS-1:0]        match
);
    localparam logic [DEST_W-1:0] BCAST = '1;

    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
        logic phys_hit;
        logic log_hit;
        assign phys_hit = (dest == BCAST) || (dest == DEST_W'(i));
        assign log_hit  = |(cpu_logical_ids[i*DEST_W +: DEST_W] & dest);
        assign match[i] = logical ? log_hit : phys_hit;
    end
endmodule

// File: rtl/irq_rotate_picker.sv
module irq_rotate_picker #(
    parameter int NUM_CPUS = 8,
    parameter int ROT_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CPUS-1:0] match,
    input  logic                advance,
    output logic [NUM_CPUS-1:0] pick
);
    localparam int CNT_W = $clog2(NUM_CPUS + 1);

    logic [ROT_W-1:0] offset;
    logic [CNT_W-1:0] count;
    logic [ROT_W-1:0] slot;

    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_CPUS; i++) begin
            count = count + CNT_W'(match[i]);
        end
        slot = (count == '0) ? '0 : (offset % ROT_W'(count));
    end

    always_comb begin
        logic [CNT_W-1:0] seen;
        seen = '0;
        pick = '0;
        for (int i = 0; i < NUM_CPUS; i++) begin
            if (match[i]) begin
                if (ROT_W'(seen) == slot) begin
                    pick[i] = 1'b1;
                end
                seen = seen + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= '0;
        end else if (advance) begin
            offset <= offset + 1'b1;
        end
    end
endmodule

// File: rtl/irq_dispatcher.sv
module irq_dispatcher
    import irq_disp_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_CPUS = 8,
    parameter int ROT_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PINS-1:0]        pin_in,
    input  logic [NUM_PINS*ENT_W-1:0]  redir_table,
    input  logic [VEC_W-1:0]           ext_vector,
    input  logic [NUM_CPUS*DEST_W-1:0] cpu_logical_ids,
    output logic                       msg_valid,
    output logic [VEC_W-1:0]           msg_vector,
    output logic [2:0]                 msg_dmode,
    output logic                       msg_logical,
    output logic                       msg_level,
    output logic                       msg_trigger,
    output logic [NUM_CPUS-1:0]        msg_targets,
    output logic                       cfg_error
);
    logic                grant_valid;
    logic [NUM_PINS-1:0] grant;
    logic [ENT_W-1:0]    raw_sel;
    route_ent_t          ent;
    logic [NUM_CPUS-1:0] match;
    logic [NUM_CPUS-1:0] pick;
    logic                is_lowest;
    logic                advance;
    act_e                act;
    logic [NUM_CPUS-1:0] targets;

    irq_edge_arbiter #(.NUM_PINS(NUM_PINS)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .pin_in      (pin_in),
        .grant_valid (grant_valid),
        .grant       (grant)
    );

    always_comb begin
        raw_sel = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (grant[p]) begin
                raw_sel = redir_table[p*ENT_W +: ENT_W];
            end
        end
        ent = decode_entry(raw_sel);
    end

    irq_target_resolver #(.NUM_CPUS(NUM_CPUS)) u_res (
        .dest            (ent.dest),
        .logical         (ent.logical),
        .cpu_logical_ids (cpu_logical_ids),
        .match           (match)
    );

    irq_rotate_picker #(.NUM_CPUS(NUM_CPUS), .ROT_W(ROT_W)) u_rot (
        .clk     (clk),
        .rst     (rst),
        .match   (match),
        .advance (advance),
        .pick    (pick)
    );

    always_comb begin
        is_lowest = (ent.dmode == DM_LOWEST);
        act = ACT_NONE;
        if (grant_valid && !ent.masked) begin
            if (is_lowest && !ent.logical) begin
                act = ACT_ERROR;
            end else if (ent.logical && (match == '0)) begin
                act = ACT_NONE;
            end else begin
                act = ACT_SEND;
            end
        end
        advance = (act == ACT_SEND) && is_lowest;
        targets = is_lowest ? pick : match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid   <= 1'b0;
            msg_vector  <= '0;
            msg_dmode   <= '0;
            msg_logical <= 1'b0;
            msg_level   <= 1'b0;
            msg_trigger <= 1'b0;
            msg_targets <= '0;
            cfg_error   <= 1'b0;
        end else begin
            msg_valid <= (act == ACT_SEND);
            cfg_error <= (act == ACT_ERROR);
            if (act == ACT_SEND) begin
                msg_vector  <= pick_vector(ent, ext_vector);
                msg_dmode   <= ent.dmode;
                msg_logical <= ent.logical;
                msg_level   <= ent.pol;
                msg_trigger <= ent.trig;
                msg_targets <= targets;
            end
        end
    end
endmodule

// File: rtl/irq_dispatcher_checker.sv
module irq_dispatcher_checker #(
    parameter int NUM_CPUS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          ext_vector,
    input logic                msg_valid,
    input logic [7:0]          msg_vector,
    input logic [2:0]          msg_dmode,
    input logic                msg_logical,
    input logic [NUM_CPUS-1:0] msg_targets,
    input logic                cfg_error
);
    // R1: the cycle after reset shows nothing
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!msg_valid && !cfg_error));

    // R12: message and error are exclusive
    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(msg_valid && cfg_error));

    // R7: a lowest-priority message is never physical
    a_r7_lowest_is_logical: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_dmode == 3'd1) |-> msg_logical);

    // R10: lowest priority reaches exactly one controller
    a_r10_single_target: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_dmode == 3'd1) |-> ($countones(msg_targets) == 1));

    // R9: a logical message always has a target
    a_r9_logical_nonempty: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_logical) |-> (msg_targets != '0));

    // R4: external-controller mode takes the sampled external vector
    a_r4_ext_vector: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_dmode == 3'd7) |-> (msg_vector == $past(ext_vector)));
endmodule

bind irq_dispatcher irq_dispatcher_checker #(.NUM_CPUS(NUM_CPUS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_vector  (ext_vector),
    .msg_valid   (msg_valid),
    .msg_vector  (msg_vector),
    .msg_dmode   (msg_dmode),
    .msg_logical (msg_logical),
    .msg_targets (msg_targets),
    .cfg_error   (cfg_error)
);

// File: tb/tb_irq_dispatcher.sv
module tb_irq_dispatcher;
    localparam int NP = 8;
    localparam int NC = 8;
    localparam int EW = 23;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   pin_in = '0;
    logic [NP*EW-1:0] redir_table = '0;
    logic [7:0]      ext_vector = '0;
    logic [NC*8-1:0] cpu_logical_ids = '0;
    logic            msg_valid;
    logic [7:0]      msg_vector;
    logic [2:0]      msg_dmode;
    logic            msg_logical;
    logic            msg_level;
    logic            msg_trigger;
    logic [NC-1:0]   msg_targets;
    logic            cfg_error;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_dispatcher #(.NUM_PINS(NP), .NUM_CPUS(NC)) dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .redir_table(redir_table),
        .ext_vector(ext_vector), .cpu_logical_ids(cpu_logical_ids),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
        .msg_logical(msg_logical), .msg_level(msg_level), .msg_trigger(msg_trigger),
        .msg_targets(msg_targets), .cfg_error(cfg_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_entry(input int p, input logic [7:0] vec, input logic [2:0] dm,
                             input logic lg, input logic pol, input logic trg,
                             input logic msk, input logic [7:0] dst);
        redir_table[p*EW +: EW] = {dst, msk, trg, pol, lg, dm, vec};
    endtask

    // raise pin, then sit at the negedge where the message is visible
    task automatic raise(input int p);
        @(negedge clk);
        pin_in[p] = 1'b1;
        @(negedge clk);
    endtask

    task automatic lower(input int p);
        pin_in[p] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(msg_valid), 0);
        chk("R1 error", 32'(cfg_error), 0);
        repeat (2) @(negedge clk);
        chk("R1 idle valid", 32'(msg_valid), 0);
    endtask

    task automatic t_fixed_phys();
        set_entry(2, 8'h41, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3);
        raise(2);
        chk("R2 first rise", 32'(msg_valid), 1);
        chk("R5 vector", 32'(msg_vector), 32'h41);
        chk("R5 dmode", 32'(msg_dmode), 0);
        chk("R5 logical", 32'(msg_logical), 0);
        chk("R5 level", 32'(msg_level), 1);
        chk("R5 trigger", 32'(msg_trigger), 1);
        chk("R6 single id", 32'(msg_targets), 32'h08);
        @(negedge clk);
        chk("R2 held high", 32'(msg_valid), 0);
        @(negedge clk);
        chk("R2 still held", 32'(msg_valid), 0);
        lower(2);
        chk("R2 lowered", 32'(msg_valid), 0);
        set_entry(2, 8'h42, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20);
        raise(2);
        chk("R2 re-rise", 32'(msg_valid), 1);
        chk("R5 nmi mode", 32'(msg_dmode), 4);
        chk("R5 level low", 32'(msg_level), 0);
        chk("R6 id out of range", 32'(msg_targets), 0);
        lower(2);
    endtask

    task automatic t_broadcast();
        set_entry(0, 8'h30, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
        raise(0);
        chk("R6 broadcast valid", 32'(msg_valid), 1);
        chk("R6 broadcast mask", 32'(msg_targets), 32'hFF);
        lower(0);
    endtask

    task automatic t_masked();
        set_entry(7, 8'h55, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF);
        raise(7);
        chk("R3 masked valid", 32'(msg_valid), 0);
        chk("R3 masked error", 32'(cfg_error), 0);
        @(negedge clk);
        chk("R3 masked later", 32'(msg_valid), 0);
        lower(7);
    endtask

    task automatic t_extint();
        ext_vector = 8'h99;
        set_entry(6, 8'h22, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
        raise(6);
        chk("R4 ext valid", 32'(msg_valid), 1);
        chk("R4 ext vector", 32'(msg_vector), 32'h99);
        chk("R4 ext mode", 32'(msg_dmode), 7);
        lower(6);
        set_entry(6, 8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
        raise(6);
        chk("R4 entry vector", 32'(msg_vector), 32'h22);
        lower(6);
    endtask

    task automatic t_phys_lowest();
        set_entry(5, 8'h60, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2);
        raise(5);
        chk("R7 error", 32'(cfg_error), 1);
        chk("R7 no msg", 32'(msg_valid), 0);
        @(negedge clk);
        chk("R7 one cycle", 32'(cfg_error), 0);
        lower(5);
    endtask

    task automatic t_logical();
        set_entry(1, 8'h70, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h05);
        raise(1);
        chk("R8 valid", 32'(msg_valid), 1);
        chk("R8 match", 32'(msg_targets), 32'h05);
        chk("R5 logical flag", 32'(msg_logical), 1);
        lower(1);
        set_entry(1, 8'h70, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        raise(1);
        chk("R9 no match", 32'(msg_valid), 0);
        chk("R9 no error", 32'(cfg_error), 0);
        lower(1);
    endtask

    task automatic t_lowest();
        set_entry(3, 8'h80, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h16);
        set_entry(4, 8'h81, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        raise(3);
        chk("R10 offset0", 32'(msg_targets), 32'h02);
        chk("R10 mode", 32'(msg_dmode), 1);
        lower(3);
        raise(3);
        chk("R10 offset1", 32'(msg_targets), 32'h04);
        lower(3);
        raise(4);
        chk("R9 lowest no match", 32'(msg_valid), 0);
        lower(4);
        raise(3);
        chk("R9 offset kept", 32'(msg_targets), 32'h10);
        lower(3);
        set_entry(3, 8'h80, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F);
        raise(3);
        chk("R10 offset3 of 4", 32'(msg_targets), 32'h08);
        lower(3);
        raise(3);
        chk("R10 wrap", 32'(msg_targets), 32'h01);
        lower(3);
    endtask

    task automatic t_simultaneous();
        set_entry(1, 8'hA1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0);
        set_entry(5, 8'hA5, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0);
        set_entry(6, 8'hA6, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0);
        @(negedge clk);
        pin_in = 8'b0110_0010;
        @(negedge clk);
        chk("R11 first", {23'd0, msg_valid, msg_vector}, 32'h1A1);
        @(negedge clk);
        chk("R11 second", {23'd0, msg_valid, msg_vector}, 32'h1A5);
        @(negedge clk);
        chk("R11 third", {23'd0, msg_valid, msg_vector}, 32'h1A6);
        @(negedge clk);
        chk("R11 drained", 32'(msg_valid), 0);
        pin_in = '0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) cpu_logical_ids[i*8 +: 8] = 8'(1 << i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fixed_phys();
        t_broadcast();
        t_masked();
        t_extint();
        t_phys_lowest();
        t_logical();
        t_lowest();
        t_simultaneous();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule